// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block is the control register of a single DMA channel, together with the small amount of sequencing logic that decides when the channel may launch a transfer unit. It stores an enable flag, a pause flag, a request-source selector, a software trigger, a destination number, a block-size field and a 16-bit remaining-transfer count. A bus-side write port loads all fields at once, and a read port always returns the current value. A separate transfer engine outside this block performs the transfers. It receives a one-cycle launch pulse from this block and answers with a completion pulse when the unit is finished.

Software does not own the enable flag outright. The channel clears the flag itself when the last counted unit completes. An all-channel disable input also clears it, and while that input is high a write of 1 to the flag is refused. A 3-bit stop-cause output records why the channel last stopped. A busy output lets software confirm that a paused channel has drained before it clears the enable flag.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads 0x00000000, `chan_busy` is 0, `xfer_start` is 0 and `stop_cause` is 0 (none).
- R2: The register layout is: bit 31 enable, bit 30 pause, bits 29:25 source select, bit 24 software trigger, bits 23:20 destination number, bits 19:16 block size, bits 15:0 transfer count. A write loads every field, and a read returns the same layout.
- R3: `xfer_start` pulses only when all of these hold: enable is 1, pause is 0, `glob_dis` is 0, no unit is outstanding, and either the selected request line or the software trigger is 1. Requests outside these conditions are ignored, and at most one unit is outstanding at a time.
- R4: The software trigger bit acts as a request. It clears itself in the cycle after its launch is accepted.
- R5: Each `xfer_done` that arrives while a unit is outstanding lowers the count by one. A `xfer_done` with nothing outstanding is ignored. A count of 0 wraps to 0xFFFF, so a count of zero gives 65536 units.
- R6: A completion that takes the count from 1 to 0 while enabled clears the enable bit and sets `stop_cause` to 1 (done).
- R7: A write of 0 to the enable bit of a running channel stops it and sets `stop_cause` to 2 (forced).
- R8: While `glob_dis` is 1, a write of 1 to the enable bit is refused. If `glob_dis` rises while the channel is enabled, the enable bit is cleared and `stop_cause` becomes 3 (global).
- R9: While pause is 1, no unit is launched and the count holds. A write that keeps the channel enabled sets `stop_cause` to 4 (paused) if pause is 1, and to 0 if pause is 0. A later unpause lets launches resume from the held count.
- R10: When a hardware clear (completion or global disable) meets a software write in the same cycle, the hardware clear decides the enable bit. A completion in the same cycle as a count write decrements the old count, and the written count is dropped.
- R11: `chan_busy` is 1 while a unit is outstanding, or while the channel is enabled and not paused.
- R12: Source select values of `NUM_SRC` or higher (24 to 31 by default) match no request line. Only the software trigger can start such a channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| glob_dis | input | 1 | All-channel disable |
| req_lines | input | NUM_SRC | Hardware transfer request lines |
| xfer_start | output | 1 | Launch pulse for one transfer unit |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| dest_num | output | 4 | Destination number field |
| blk_size | output | 4 | Block-size field |
| chan_busy | output | 1 | Channel is active or draining |
| stop_cause | output | 3 | Cause of the last stop |

## Verification
The launch decision is exercised with random request lines, random completion pulses, random register writes and occasional global-disable pulses. A bench model predicts the launch pulse, the readback, busy and stop cause every cycle. This random mix separates a launch gated by enable and pause from one gated by an outstanding unit, and it shows which source line the selector really picks. Directed runs cover the cases the random mix rarely hits:
- a zero count that must wrap rather than stop;
- exhaustion that collides with a same-cycle write;
- a write of 1 that is refused under global disable;
- a reserved selector with every request line asserted;
- a software trigger with all lines quiet.

// File: rtl/dma_chan_pkg.sv
// Shared field positions and stop-cause codes for the DMA channel control register.
// Assumes a 32-bit register with the field order fixed by the consumers that decode it.
package dma_chan_pkg;
    localparam int REG_W     = 32;
    localparam int CNT_W     = 16;
    localparam int SEL_W     = 5;
    localparam int NUM_W     = 4;
    localparam int EN_BIT    = 31;
    localparam int PAUSE_BIT = 30;
    localparam int SEL_LSB   = 25;
    localparam int TRIG_BIT  = 24;
    localparam int DEST_LSB  = 20;
    localparam int BLK_LSB   = 16;
    localparam int CNT_LSB   = 0;

    typedef enum logic [2:0] {
        STOP_NONE   = 3'd0,
        STOP_DONE   = 3'd1,
        STOP_FORCED = 3'd2,
        STOP_GLOBAL = 3'd3,
        STOP_PAUSED = 3'd4
    } stop_cause_e;
endpackage

// File: rtl/dma_chan_ctl.sv
// Holds the enable, pause, trigger, selector, destination and block fields, and the stop cause.
// Assumes exhaust and start are single-cycle pulses from the counter and the launch logic.
// Hardware clears (exhaust, global disable) take priority over software writes of enable.
module dma_chan_ctl
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             wr_en,
    input  logic             wr_pause,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_trig,
    input  logic [NUM_W-1:0] wr_dest,
    input  logic [NUM_W-1:0] wr_blk,
    input  logic             glob_dis,
    input  logic             exhaust,
    input  logic             start,
    output logic             en_q,
    output logic             pause_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             trig_q,
    output logic [NUM_W-1:0] dest_q,
    output logic [NUM_W-1:0] blk_q,
    output stop_cause_e      cause_q
);
    logic        en_d;
    logic        trig_d;
    logic        glob_kill;
    logic        stays_on;
    stop_cause_e cause_d;

    // Purpose: decide next enable, trigger and stop cause under the hardware-first priority.
    always_comb begin
        glob_kill = glob_dis & en_q;
        stays_on  = reg_wr & wr_en & ~glob_dis;
        en_d      = en_q;
        if (reg_wr) en_d = wr_en & ~glob_dis;
        if (exhaust | glob_kill) en_d = 1'b0;

        cause_d = cause_q;
        if (reg_wr && en_q && !wr_en) cause_d = STOP_FORCED;
        if (stays_on) cause_d = wr_pause ? STOP_PAUSED : STOP_NONE;
        if (glob_kill) cause_d = STOP_GLOBAL;
        if (exhaust) cause_d = STOP_DONE;

        trig_d = trig_q;
        if (start) trig_d = 1'b0;
        if (reg_wr) trig_d = wr_trig;
    end

    // Purpose: register all control fields with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            pause_q <= 1'b0;
            sel_q   <= '0;
            trig_q  <= 1'b0;
            dest_q  <= '0;
            blk_q   <= '0;
            cause_q <= STOP_NONE;
        end else begin
            en_q    <= en_d;
            trig_q  <= trig_d;
            cause_q <= cause_d;
            if (reg_wr) begin
                pause_q <= wr_pause;
                sel_q   <= wr_sel;
                dest_q  <= wr_dest;
                blk_q   <= wr_blk;
            end
        end
    end

    AST_EXHAUST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exhaust |=> (!en_q && cause_q == STOP_DONE)); // R6
    AST_GDIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        glob_dis |=> !en_q); // R8
endmodule

// File: rtl/dma_chan_cnt.sv
// Remaining-transfer counter: loaded by software writes, lowered by accepted completions.
// Assumes dec is already qualified with an outstanding unit; a zero count wraps (65536 units).
module dma_chan_cnt
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             dec,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             exhaust
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    // Purpose: flag the completion that consumes the final counted unit of an enabled channel.
    always_comb exhaust = dec & en & (cnt_q == LAST);

    // Purpose: update the count; a completion wins over a same-cycle software load.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (dec)    cnt_q <= cnt_q - LAST;
        else if (reg_wr) cnt_q <= wr_cnt;
    end

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (cnt_q == $past(cnt_q) - LAST)); // R5
endmodule

// File: rtl/dma_chan_launch.sv
// Picks the selected request line, issues launch pulses, tracks the single outstanding unit.
// Assumes request lines are synchronous; selector values past NUM_SRC see a quiet line.
module dma_chan_launch
    import dma_chan_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_lines,
    input  logic [SEL_W-1:0]   sel,
    input  logic               trig,
    input  logic               en,
    input  logic               pause,
    input  logic               glob_dis,
    input  logic               xfer_done,
    output logic               start,
    output logic               dec,
    output logic               infl_q
);
    localparam int SEL_SPAN = 1 << SEL_W;

    logic [SEL_SPAN-1:0] line_pad;
    logic                want;

    // Widen the request vector to the selector span; unused codes read as quiet lines.
    for (genvar i = 0; i < SEL_SPAN; i++) begin : g_pad
        if (i < NUM_SRC) begin : g_live
            assign line_pad[i] = req_lines[i];
        end else begin : g_dead
            assign line_pad[i] = 1'b0;
        end
    end

    // Purpose: combine request, gating and outstanding state into launch and count pulses.
    always_comb begin
        want  = line_pad[sel] | trig;
        start = en & ~pause & ~glob_dis & ~infl_q & want;
        dec   = xfer_done & infl_q;
    end

    // Purpose: remember whether a launched unit still awaits its completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     infl_q <= 1'b0;
        else if (start) infl_q <= 1'b1;
        else if (dec)   infl_q <= 1'b0;
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
// Top of the per-channel DMA control register: bus write/read, launch handshake, status.
// Assumes a full 32-bit write per strobe and an external engine that answers each launch.
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               glob_dis,
    input  logic [NUM_SRC-1:0] req_lines,
    output logic               xfer_start,
    input  logic               xfer_done,
    output logic [3:0]         dest_num,
    output logic [3:0]         blk_size,
    output logic               chan_busy,
    output logic [2:0]         stop_cause
);
    logic             en_q, pause_q, trig_q, infl_q, exhaust, dec, start;
    logic [SEL_W-1:0] sel_q;
    logic [NUM_W-1:0] dest_q, blk_q;
    logic [CNT_W-1:0] cnt_q;
    stop_cause_e      cause_q;

    dma_chan_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .wr_en    (reg_wdata[EN_BIT]),
        .wr_pause (reg_wdata[PAUSE_BIT]),
        .wr_sel   (reg_wdata[SEL_LSB +: SEL_W]),
        .wr_trig  (reg_wdata[TRIG_BIT]),
        .wr_dest  (reg_wdata[DEST_LSB +: NUM_W]),
        .wr_blk   (reg_wdata[BLK_LSB +: NUM_W]),
        .glob_dis (glob_dis),
        .exhaust  (exhaust),
        .start    (start),
        .en_q     (en_q),
        .pause_q  (pause_q),
        .sel_q    (sel_q),
        .trig_q   (trig_q),
        .dest_q   (dest_q),
        .blk_q    (blk_q),
        .cause_q  (cause_q)
    );

    dma_chan_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_wr  (reg_wr),
        .wr_cnt  (reg_wdata[CNT_LSB +: CNT_W]),
        .dec     (dec),
        .en      (en_q),
        .cnt_q   (cnt_q),
        .exhaust (exhaust)
    );

    dma_chan_launch #(.NUM_SRC(NUM_SRC)) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_lines (req_lines),
        .sel       (sel_q),
        .trig      (trig_q),
        .en        (en_q),
        .pause     (pause_q),
        .glob_dis  (glob_dis),
        .xfer_done (xfer_done),
        .start     (start),
        .dec       (dec),
        .infl_q    (infl_q)
    );

    // Purpose: assemble the readback word and drive the status outputs.
    always_comb begin
        reg_rdata  = {en_q, pause_q, sel_q, trig_q, dest_q, blk_q, cnt_q};
        xfer_start = start;
        dest_num   = dest_q;
        blk_size   = blk_q;
        chan_busy  = infl_q | (en_q & ~pause_q);
        stop_cause = cause_q;
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (reg_rdata[EN_BIT] && !reg_rdata[PAUSE_BIT] && !glob_dis)); // R3
    AST_START_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (chan_busy && !xfer_start)); // R3
    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_q && !infl_q && !reg_wr) |=> $stable(cnt_q)); // R9
endmodule

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 24;
    localparam logic [31:0] F_EN = 32'h8000_0000;
    localparam logic [31:0] F_PA = 32'h4000_0000;
    localparam logic [31:0] F_TR = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [31:0] wd = '0;
    logic gd = 1'b0;
    logic [NSRC-1:0] rq = '0;
    logic dn = 1'b0;
    logic [31:0] rdata;
    logic start, busy;
    logic [3:0] dest, blk;
    logic [2:0] cause;

    int checks = 0, fails = 0;
    bit auto_done = 1'b0;
    bit finished = 1'b0;

    logic m_en, m_pa, m_tr, m_infl;
    logic [4:0] m_sel;
    logic [3:0] m_dest, m_blk;
    logic [15:0] m_cnt;
    logic [2:0] m_cause;

    dma_chan_ctrl #(.NUM_SRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_wdata(wd), .reg_rdata(rdata),
        .glob_dis(gd), .req_lines(rq), .xfer_start(start), .xfer_done(dn),
        .dest_num(dest), .blk_size(blk), .chan_busy(busy), .stop_cause(cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_start();
        logic line;
        line = (m_sel < NSRC) ? rq[m_sel] : 1'b0;
        return m_en & ~m_pa & ~gd & ~m_infl & (line | m_tr);
    endfunction

    function automatic logic [31:0] exp_rd();
        return {m_en, m_pa, m_sel, m_tr, m_dest, m_blk, m_cnt};
    endfunction

    task automatic model_reset();
        m_en = 0; m_pa = 0; m_tr = 0; m_infl = 0; m_sel = 0;
        m_dest = 0; m_blk = 0; m_cnt = 0; m_cause = 0;
    endtask

    task automatic model_step(input logic st);
        logic dok, exh, gk;
        dok = dn & m_infl;
        exh = dok & m_en & (m_cnt == 16'd1);
        gk  = gd & m_en;
        if (wr && m_en && !wd[31]) m_cause = 3'd2;
        if (wr && wd[31] && !gd) m_cause = wd[30] ? 3'd4 : 3'd0;
        if (gk) m_cause = 3'd3;
        if (exh) m_cause = 3'd1;
        if (wr) m_en = wd[31] & ~gd;
        if (exh || gk) m_en = 1'b0;
        if (st) m_tr = 1'b0;
        if (wr) begin
            m_tr = wd[24]; m_pa = wd[30]; m_sel = wd[29:25];
            m_dest = wd[23:20]; m_blk = wd[19:16];
        end
        if (dok) m_cnt = m_cnt - 16'd1;
        else if (wr) m_cnt = wd[15:0];
        if (st) m_infl = 1'b1;
        else if (dok) m_infl = 1'b0;
    endtask

    // One clock: inputs already driven after a negedge; check, clock, update model.
    task automatic cycle();
        logic st;
        if (auto_done) dn = m_infl;
        #1;
        st = exp_start();
        chk("R3", "launch pulse", {31'd0, start}, {31'd0, st});
        chk("R2", "readback", rdata, exp_rd());
        chk("R11", "busy", {31'd0, busy}, {31'd0, m_infl | (m_en & ~m_pa)});
        chk("R6", "stop cause", {29'd0, cause}, {29'd0, m_cause});
        @(posedge clk);
        model_step(st);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [31:0] d);
        wr = 1'b1; wd = d;
        cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "reset readback", rdata, 32'h0);
        chk("R1", "reset busy", {31'd0, busy}, 32'd0);
        chk("R1", "reset launch", {31'd0, start}, 32'd0);
        chk("R1", "reset cause", {29'd0, cause}, 32'd0);

        // R2: every field loads and reads back in place
        wr_reg(32'h7FFF_1234);
        #1;
        chk("R2", "field readback", rdata, 32'h7FFF_1234);
        chk("R2", "dest/blk outputs", {24'd0, dest, blk}, 32'h0000_00FF);

        // R5: zero count wraps and keeps running
        rq = '0; rq[0] = 1'b1; auto_done = 1'b1;
        wr_reg(F_EN);
        repeat (6) cycle();
        rq = '0;
        cycle();
        chk("R5", "zero count wrap", {16'd0, rdata[15:0]}, 32'h0000_FFFD);
        chk("R5", "still enabled", {31'd0, rdata[31]}, 32'd1);

        // R6: exhaustion stops the channel
        rq[0] = 1'b1;
        wr_reg(F_EN | 32'd2);
        repeat (4) cycle();
        #1;
        chk("R6", "enable cleared", {31'd0, rdata[31]}, 32'd0);
        chk("R6", "cause done", {29'd0, cause}, 32'd1);
        chk("R6", "count zero", {16'd0, rdata[15:0]}, 32'd0);
        rq = '0; auto_done = 1'b0;

        // R7: forced stop
        wr_reg(F_EN | 32'd9);
        wr_reg(32'd9);
        #1;
        chk("R7", "cause forced", {29'd0, cause}, 32'd2);

        // R8: global disable clears and refuses enable
        wr_reg(F_EN | 32'd9);
        gd = 1'b1;
        cycle();
        #1;
        chk("R8", "forced by global", {31'd0, rdata[31]}, 32'd0);
        chk("R8", "cause global", {29'd0, cause}, 32'd3);
        wr_reg(F_EN | 32'd9);
        #1;
        chk("R8", "write of one refused", {31'd0, rdata[31]}, 32'd0);
        gd = 1'b0;

        // R9: pause holds count and blocks launch; unpause resumes
        rq[2] = 1'b1;
        wr_reg(F_EN | F_PA | (32'd2 << 25) | 32'd5);
        repeat (3) cycle();
        #1;
        chk("R9", "no launch while paused", {31'd0, start}, 32'd0);
        chk("R9", "count held", {16'd0, rdata[15:0]}, 32'd5);
        chk("R9", "cause paused", {29'd0, cause}, 32'd4);
        wr_reg(F_EN | (32'd2 << 25) | 32'd5);
        #1;
        chk("R9", "launch after unpause", {31'd0, start}, 32'd1);
        chk("R9", "cause cleared", {29'd0, cause}, 32'd0);
        cycle();
        // R11: paused with a unit outstanding stays busy until done
        wr_reg(F_EN | F_PA | (32'd2 << 25) | 32'd5);
        #1;
        chk("R11", "busy while draining", {31'd0, busy}, 32'd1);
        dn = 1'b1; cycle(); dn = 1'b0;
        #1;
        chk("R11", "idle after drain", {31'd0, busy}, 32'd0);
        rq = '0;

        // R10: completion beats a same-cycle write
        rq[1] = 1'b1;
        wr_reg(F_EN | (32'd1 << 25) | 32'd1);
        cycle();
        rq = '0;
        dn = 1'b1; wr = 1'b1; wd = F_EN | (32'd1 << 25) | 32'd5;
        cycle();
        dn = 1'b0;
        #1;
        chk("R10", "enable stays cleared", {31'd0, rdata[31]}, 32'd0);
        chk("R10", "count decremented", {16'd0, rdata[15:0]}, 32'd0);
        chk("R10", "cause done", {29'd0, cause}, 32'd1);

        // R4: software trigger launches and clears itself
        wr_reg(F_EN | F_TR | (32'd3 << 25) | 32'd4);
        #1;
        chk("R4", "trigger launches", {31'd0, start}, 32'd1);
        cycle();
        #1;
        chk("R4", "trigger cleared", {31'd0, rdata[24]}, 32'd0);
        dn = 1'b1; cycle(); dn = 1'b0;

        // R12: reserved selector sees no request line
        rq = '1;
        wr_reg(F_EN | (32'd25 << 25) | 32'd4);
        repeat (2) cycle();
        #1;
        chk("R12", "reserved select idle", {31'd0, start}, 32'd0);
        chk("R12", "count untouched", {16'd0, rdata[15:0]}, 32'd4);
        rq = '0;

        // Random mix checked every cycle against the model (R3, R5, R6, R8, R9)
        for (int i = 0; i < 3000; i++) begin
            rq = NSRC'($urandom & $urandom);
            dn = ($urandom % 2) == 0;
            gd = ($urandom % 64) == 0;
            if (($urandom % 16) == 0) begin
                wr = 1'b1;
                wd = {($urandom % 4) != 0, ($urandom % 5) == 0, 5'($urandom),
                      ($urandom % 4) == 0, 8'($urandom), 16'($urandom % 6)};
            end
            cycle();
        end
        gd = 1'b0; dn = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule